// File: doc/BRIEF.md
# Pixel Alpha Blend and Offset Unit

This block is one processing stage in the pixel path of a 2D drawing engine. It takes one source pixel and the destination pixel it will replace, both 16 bits wide, in either 5-6-5 RGB or 1-5-5-5 ARGB layout. It then returns the pixel to be written. Two steps can be applied to each channel, in this order. The first adds a signed per-channel colour offset to the source and clamps the sum to the channel's range. The second mixes the result with the destination using an 8-bit alpha weight. The blend uses reduced precision: red and blue use the top five alpha bits. Green uses the top six bits in 5-6-5 mode and the top five in 1-5-5-5 mode.

Two configuration registers hold the alpha weight and the packed offsets. Neither register is cleared by reset. Both pixel streams use a valid/ready handshake. One output register, run by a two-state machine, gives a latency of one cycle and full throughput.

The output stage has two states. `OS_IDLE` means no pixel is held. `OS_HOLD` means a pixel is on the output. The transitions are:
- `OS_IDLE` to `OS_HOLD` on an accepted input.
- `OS_HOLD` to `OS_HOLD` while the output is stalled, or when a new input is accepted in the same cycle that the held pixel leaves.
- `OS_HOLD` to `OS_IDLE` when the held pixel leaves and no input arrives.

Top module: `pix_blend_unit`

## Requirements
- R1: The alpha register is selected by `cfg_sel`=0 (write) and `cfg_rd_sel`=0 (read). Bits 7:0 store the written value. Bits 31:8 read as zero whatever was written.
- R2: The offset register is selected by `cfg_sel`=1 (write) and `cfg_rd_sel`=1 (read). It holds a signed red offset in bits 15:11 (5 bits), a signed green offset in bits 10:5 (6 bits) and a signed blue offset in bits 4:0 (5 bits). Bits 31:16 read as zero.
- R3: Both configuration registers keep their contents across an assertion of `rst_n`.
- R4: With `in_blend_en`=0 and `in_ofs_en`=0, the colour channels of the output equal those of the source.
- R5: With `in_ofs_en`=1, each channel becomes the source channel plus its sign-extended offset field, clamped to 0 and to the channel maximum. In 1-5-5-5 mode the green maximum is 31 and the 6-bit green field is still used.
- R6: With `in_blend_en`=1, the red and blue channels become (s·a + d·(31−a)) / 31, truncated, where a = alpha[7:3].
- R7: With `in_blend_en`=1, green uses n = 6 and a = alpha[7:2] in 5-6-5 mode (`in_fmt`=0). It uses n = 5 and a = alpha[7:3] in 1-5-5-5 mode (`in_fmt`=1). Either way the result is (s·a + d·(2^n−1−a)) / (2^n−1), truncated.
- R8: In 1-5-5-5 mode, output bit 15 equals the destination's bit 15. The channel fields are red 14:10, green 9:5 and blue 4:0. In 5-6-5 mode they are red 15:11, green 10:5 and blue 4:0.
- R9: When both enables are set, the offset is applied to the source before blending.
- R10: A pixel accepted on an edge (`in_valid` and `in_ready`) appears on the output after that edge. It stays stable while `out_valid`=1 and `out_ready`=0. `in_ready` is high when no pixel is held or `out_ready` is high.
- R11: While `rst_n`=0 the output stage empties: `out_valid` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 alpha, 1 offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rd_sel | input | 1 | Read source: 0 alpha, 1 offset |
| cfg_rdata | output | 32 | Register read data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_src | input | 16 | Source pixel |
| in_dst | input | 16 | Destination pixel |
| in_fmt | input | 1 | 0: 5-6-5 RGB, 1: 1-5-5-5 ARGB |
| in_blend_en | input | 1 | Enable alpha blending |
| in_ofs_en | input | 1 | Enable colour offset |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output consumer ready |
| out_pix | output | 16 | Resulting pixel |

## Verification
A wrong state in the output machine shows up at the ports within one cycle. A pixel may be lost, a pixel may be sent twice, or `out_pix` may change while the output is stalled. The bench scoreboard catches each of these on the next output handshake. A corrupted configuration register gives wrong channel values on every later pixel that uses it, and it also shows on the next register read. The alpha value 0x84 is chosen so that its five-bit and six-bit truncations differ, which exposes a green channel that uses the wrong precision.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
    localparam int PIX_W   = 16;
    localparam int CFG_W   = 32;
    localparam int ALPHA_W = 8;
    localparam int CH_W    = 6;
    localparam int N_CH    = 3;
    localparam int NUM_W   = 2 * CH_W;

    typedef enum logic {
        FMT_RGB565   = 1'b0,
        FMT_ARGB1555 = 1'b1
    } pix_fmt_e;

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_HOLD = 1'b1
    } os_state_e;

    typedef logic [CH_W-1:0] chan_t;
endpackage

// File: rtl/pbu_cfg_regs.sv
module pbu_cfg_regs
    import pbu_pkg::*;
#(
    parameter int DATA_W  = CFG_W,
    parameter int AL_W    = ALPHA_W,
    parameter int OFS_W   = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [AL_W-1:0]   alpha_q,
    output logic [OFS_W-1:0]  ofs_q
);
    // No reset on purpose: the contents survive a reset of the pixel path.
    always_ff @(posedge clk) begin
        if (wr_en && !wr_sel) begin
            alpha_q <= wr_data[AL_W-1:0];
        end
        if (wr_en && wr_sel) begin
            ofs_q <= wr_data[OFS_W-1:0];
        end
    end

    always_comb begin
        if (rd_sel) begin
            rd_data = {{(DATA_W-OFS_W){1'b0}}, ofs_q};
        end else begin
            rd_data = {{(DATA_W-AL_W){1'b0}}, alpha_q};
        end
    end
endmodule

// File: rtl/pbu_chan.sv
module pbu_chan
    import pbu_pkg::*;
#(
    parameter int W    = CH_W,
    parameter int AW   = ALPHA_W,
    parameter int NW   = NUM_W
) (
    input  logic [W-1:0]        src,
    input  logic [W-1:0]        dst,
    input  logic signed [W-1:0] ofs,
    input  logic                wide,
    input  logic                ofs_en,
    input  logic                blend_en,
    input  logic [AW-1:0]       alpha,
    output logic [W-1:0]        res
);
    localparam int SUM_W = W + 2;
    localparam int MAX_WIDE   = (1 << W) - 1;
    localparam int MAX_NARROW = (1 << (W - 1)) - 1;

    logic [W-1:0]           maxv;
    logic [W-1:0]           a_tr;
    logic signed [SUM_W-1:0] sum;
    logic [W-1:0]           off_res;
    logic [NW-1:0]          num;
    logic [NW-1:0]          q_wide;
    logic [NW-1:0]          q_narrow;

    always_comb begin
        maxv = wide ? W'(MAX_WIDE) : W'(MAX_NARROW);
        a_tr = wide ? alpha[AW-1 -: W] : {1'b0, alpha[AW-1 -: (W-1)]};
    end

    // Signed saturating offset stage.
    always_comb begin
        sum = $signed({2'b00, src}) + SUM_W'(ofs);
        if (!ofs_en) begin
            off_res = src;
        end else if (sum < 0) begin
            off_res = '0;
        end else if (sum > $signed({2'b00, maxv})) begin
            off_res = maxv;
        end else begin
            off_res = sum[W-1:0];
        end
    end

    // Blend stage with constant divisors selected by channel width.
    always_comb begin
        num      = NW'(off_res) * NW'(a_tr) + NW'(dst) * NW'(maxv - a_tr);
        q_wide   = num / NW'(MAX_WIDE);
        q_narrow = num / NW'(MAX_NARROW);
        if (!blend_en) begin
            res = off_res;
        end else if (wide) begin
            res = q_wide[W-1:0];
        end else begin
            res = q_narrow[W-1:0];
        end
    end
endmodule

// File: rtl/pbu_out_stage.sv
module pbu_out_stage
    import pbu_pkg::*;
#(
    parameter int DW = PIX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    os_state_e state_q, state_d;
    logic      accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            OS_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    state_d = OS_HOLD;
                end
            end
            OS_HOLD: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready && !in_valid) begin
                    state_d = OS_IDLE;
                end
            end
        endcase
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (accept) begin
            out_data <= in_data;
        end
    end
endmodule

// File: rtl/pix_blend_unit.sv
module pix_blend_unit
    import pbu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        cfg_rd_sel,
    output logic [31:0] cfg_rdata,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_src,
    input  logic [15:0] in_dst,
    input  logic        in_fmt,
    input  logic        in_blend_en,
    input  logic        in_ofs_en,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [15:0] out_pix
);
    localparam int CH_R = 0;
    localparam int CH_G = 1;
    localparam int CH_B = 2;

    logic [ALPHA_W-1:0] alpha_q;
    logic [15:0]        ofs_q;
    pix_fmt_e           fmt;

    chan_t              ch_src [N_CH];
    chan_t              ch_dst [N_CH];
    chan_t              ch_res [N_CH];
    logic signed [CH_W-1:0] ch_ofs [N_CH];
    logic               ch_wide [N_CH];
    logic [PIX_W-1:0]   pix_d;

    assign fmt = pix_fmt_e'(in_fmt);

    pbu_cfg_regs #(
        .DATA_W (CFG_W),
        .AL_W   (ALPHA_W),
        .OFS_W  (16)
    ) u_regs (
        .clk     (clk),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .rd_sel  (cfg_rd_sel),
        .rd_data (cfg_rdata),
        .alpha_q (alpha_q),
        .ofs_q   (ofs_q)
    );

    // Unpack both pixels into 6-bit channel lanes.
    always_comb begin
        if (fmt == FMT_ARGB1555) begin
            ch_src[CH_R] = {1'b0, in_src[14:10]};
            ch_src[CH_G] = {1'b0, in_src[9:5]};
            ch_dst[CH_R] = {1'b0, in_dst[14:10]};
            ch_dst[CH_G] = {1'b0, in_dst[9:5]};
        end else begin
            ch_src[CH_R] = {1'b0, in_src[15:11]};
            ch_src[CH_G] = in_src[10:5];
            ch_dst[CH_R] = {1'b0, in_dst[15:11]};
            ch_dst[CH_G] = in_dst[10:5];
        end
        ch_src[CH_B] = {1'b0, in_src[4:0]};
        ch_dst[CH_B] = {1'b0, in_dst[4:0]};
        ch_ofs[CH_R] = $signed({ofs_q[15], ofs_q[15:11]});
        ch_ofs[CH_G] = $signed(ofs_q[10:5]);
        ch_ofs[CH_B] = $signed({ofs_q[4], ofs_q[4:0]});
        ch_wide[CH_R] = 1'b0;
        ch_wide[CH_G] = (fmt == FMT_RGB565);
        ch_wide[CH_B] = 1'b0;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        pbu_chan #(
            .W  (CH_W),
            .AW (ALPHA_W),
            .NW (NUM_W)
        ) u_chan (
            .src      (ch_src[c]),
            .dst      (ch_dst[c]),
            .ofs      (ch_ofs[c]),
            .wide     (ch_wide[c]),
            .ofs_en   (in_ofs_en),
            .blend_en (in_blend_en),
            .alpha    (alpha_q),
            .res      (ch_res[c])
        );
    end

    // Repack into the selected layout.
    always_comb begin
        if (fmt == FMT_ARGB1555) begin
            pix_d = {in_dst[15], ch_res[CH_R][4:0], ch_res[CH_G][4:0], ch_res[CH_B][4:0]};
        end else begin
            pix_d = {ch_res[CH_R][4:0], ch_res[CH_G], ch_res[CH_B][4:0]};
        end
    end

    pbu_out_stage #(
        .DW (PIX_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (pix_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_pix)
    );
endmodule

// File: rtl/pbu_chk.sv
module pbu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_rd_sel,
    input logic [31:0] cfg_rdata,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] in_src,
    input logic [15:0] in_dst,
    input logic        in_fmt,
    input logic        in_blend_en,
    input logic        in_ofs_en,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_pix
);
    // R1
    alpha_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_sel |-> cfg_rdata[31:8] == 24'd0);

    // R2
    ofs_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_sel |-> cfg_rdata[31:16] == 16'd0);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix));

    // R10
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R10
    ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready);

    // R8
    alpha_bit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_fmt |=> out_pix[15] == $past(in_dst[15]));

    // R4
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_fmt && !in_blend_en && !in_ofs_en
        |=> out_pix == $past(in_src));

    // R11
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind pix_blend_unit pbu_chk u_pbu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rd_sel  (cfg_rd_sel),
    .cfg_rdata   (cfg_rdata),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_src      (in_src),
    .in_dst      (in_dst),
    .in_fmt      (in_fmt),
    .in_blend_en (in_blend_en),
    .in_ofs_en   (in_ofs_en),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_pix     (out_pix)
);

// File: tb/pix_blend_unit_bench.sv
`timescale 1ns/1ps
module pix_blend_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rd_sel = 1'b0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_src = '0;
    logic [15:0] in_dst = '0;
    logic        in_fmt = 1'b0;
    logic        in_blend_en = 1'b0;
    logic        in_ofs_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_pix;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit stall_mode = 1'b0;
    bit done = 1'b0;

    logic [7:0]  m_alpha;
    logic [15:0] m_ofs;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pix_blend_unit u_pix_blend_unit (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rd_sel(cfg_rd_sel), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_dst(in_dst),
        .in_fmt(in_fmt), .in_blend_en(in_blend_en), .in_ofs_en(in_ofs_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int mx);
        if (v < 0) return 0;
        if (v > mx) return mx;
        return v;
    endfunction

    // Expected pixel computed from the requirements R4..R9.
    function automatic logic [15:0] model(input logic [15:0] s, input logic [15:0] d,
                                          input bit f, input bit be, input bit oe);
        int sv[3], dv[3], mx[3], ov[3], an, v;
        logic [15:0] r;
        if (f) begin
            sv[0] = s[14:10]; sv[1] = s[9:5]; dv[0] = d[14:10]; dv[1] = d[9:5]; mx[1] = 31;
        end else begin
            sv[0] = s[15:11]; sv[1] = s[10:5]; dv[0] = d[15:11]; dv[1] = d[10:5]; mx[1] = 63;
        end
        sv[2] = s[4:0]; dv[2] = d[4:0]; mx[0] = 31; mx[2] = 31;
        ov[0] = int'($signed(m_ofs[15:11]));
        ov[1] = int'($signed(m_ofs[10:5]));
        ov[2] = int'($signed(m_ofs[4:0]));
        for (int c = 0; c < 3; c++) begin
            v = sv[c];
            if (oe) v = clampi(v + ov[c], mx[c]);
            if (be) begin
                an = (mx[c] == 63) ? int'(m_alpha >> 2) : int'(m_alpha >> 3);
                v = (v * an + dv[c] * (mx[c] - an)) / mx[c];
            end
            sv[c] = v;
        end
        if (f) r = {d[15], 5'(sv[0]), 5'(sv[1]), 5'(sv[2])};
        else   r = {5'(sv[0]), 6'(sv[1]), 5'(sv[2])};
        return r;
    endfunction

    task automatic cfg_write(input bit sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (sel) m_ofs = data[15:0]; else m_alpha = data[7:0];
    endtask

    task automatic cfg_read(input bit sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_rd_sel = sel;
        #1;
        check(cfg_rdata === exp, req, cfg_rdata, exp);
    endtask

    task automatic send(input logic [15:0] s, input logic [15:0] d, input bit f,
                        input bit be, input bit oe, input string req);
        @(negedge clk);
        in_src = s; in_dst = d; in_fmt = f; in_blend_en = be; in_ofs_en = oe;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(s, d, f, be, oe));
        tag_q.push_back(req);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Monitor / scoreboard, with the stall check for R10.
    initial begin
        bit          prev_stall = 1'b0;
        logic [15:0] prev_pix = '0;
        logic [15:0] e;
        string       t;
        forever begin
            @(negedge clk);
            out_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
            #2;
            if (rst_n && prev_stall) begin
                check(out_valid && out_pix == prev_pix, "R10 hold", {15'd0, out_valid, out_pix}, {16'd1, prev_pix});
            end
            prev_stall = rst_n && out_valid && !out_ready;
            prev_pix = out_pix;
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 extra", {16'd0, out_pix}, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_pix === e, t, {16'd0, out_pix}, {16'd0, e});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_alpha = '0;
        m_ofs = '0;
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        check(out_valid == 1'b0, "R11 out_valid", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R11 in_ready", {31'd0, in_ready}, 32'd1);
        // R1, R2: register access during reset still allowed
        cfg_write(1'b0, 32'hFFFF_FF5A);
        cfg_read(1'b0, 32'h0000_005A, "R1");
        cfg_write(1'b1, 32'hABCD_1234);
        cfg_read(1'b1, 32'h0000_1234, "R2");
        @(negedge clk);
        rst_n = 1'b1;
        cfg_write(1'b0, 32'h0000_00A5);
        cfg_write(1'b1, 32'h0000_7C1F);
        // R3: retention over reset
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cfg_read(1'b0, 32'h0000_00A5, "R3 alpha");
        cfg_read(1'b1, 32'h0000_7C1F, "R3 offset");

        // R4 / R8 pass-through
        send(16'hF81F, 16'h1234, 1'b0, 1'b0, 1'b0, "R4 565");
        send(16'h07E0, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R4 565b");
        send(16'h7BDE, 16'h8000, 1'b1, 1'b0, 1'b0, "R8 1555 A=1");
        send(16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b0, "R8 1555 A=0");
        drain();

        // R5 positive saturation: R=+15, G=+31, B=+15
        cfg_write(1'b1, {16'd0, 5'd15, 6'd31, 5'd15});
        send(16'hE71C, 16'h0000, 1'b0, 1'b0, 1'b1, "R5 pos 565");
        send(16'h2104, 16'h0000, 1'b0, 1'b0, 1'b1, "R5 pos small");
        send(16'h6318, 16'h8000, 1'b1, 1'b0, 1'b1, "R5 pos 1555");
        drain();
        // R5 negative saturation: R=-16, G=-3, B=-1
        cfg_write(1'b1, {16'd0, 5'b10000, 6'b111101, 5'b11111});
        send(16'h8841, 16'h0000, 1'b0, 1'b0, 1'b1, "R5 neg 565");
        send(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, "R5 neg zero");
        send(16'h0421, 16'h8000, 1'b1, 1'b0, 1'b1, "R5 neg 1555");
        drain();

        // R6 / R7 blending, 0x84 separates 5-bit and 6-bit alpha
        foreach (m_ofs[i]) ;
        cfg_write(1'b0, 32'h0000_0084);
        send(16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0, "R7 565 green6");
        send(16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b0, "R6 565 dst");
        send(16'h7FFF, 16'h8000, 1'b1, 1'b1, 1'b0, "R7 1555 green5");
        cfg_write(1'b0, 32'h0000_00FF);
        send(16'hA5A5, 16'h5A5A, 1'b0, 1'b1, 1'b0, "R6 alpha max");
        cfg_write(1'b0, 32'h0000_0000);
        send(16'hA5A5, 16'h5A5A, 1'b0, 1'b1, 1'b0, "R6 alpha zero");
        cfg_write(1'b0, 32'h0000_0077);
        send(16'h1357, 16'hFDB9, 1'b0, 1'b1, 1'b0, "R6 mid 565");
        send(16'h1357, 16'hFDB9, 1'b1, 1'b1, 1'b0, "R7 mid 1555");
        drain();

        // R9 offset then blend
        cfg_write(1'b1, {16'd0, 5'd7, 6'b110000, 5'd12});
        cfg_write(1'b0, 32'h0000_00C3);
        send(16'hC618, 16'h39E7, 1'b0, 1'b1, 1'b1, "R9 565");
        send(16'h4210, 16'hBDEF, 1'b1, 1'b1, 1'b1, "R9 1555");
        drain();

        // R10 back-pressure with a burst
        stall_mode = 1'b1;
        for (int k = 0; k < 12; k++) begin
            send(16'(k * 16'h1111 + 16'h0123), 16'(16'hF0F0 ^ (k * 16'h0707)),
                 k[0], k[1], k[2], "R10 burst");
        end
        repeat (40) @(negedge clk);
        stall_mode = 1'b0;
        drain();
        check(exp_q.size() == 0, "R10 drained", exp_q.size(), 32'd0);

        // R11: reset empties a held pixel
        stall_mode = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        in_src = 16'h0F0F; in_dst = 16'h0; in_fmt = 1'b0; in_blend_en = 1'b0; in_ofs_en = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R11 flush", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        stall_mode = 1'b0;
        exp_q.delete();
        tag_q.delete();
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule